// File: doc/BRIEF.md
# Register-Mapped Floppy Track Controller

This block is a simplified disk controller that a processor programs through four byte-wide registers, selected by a two-bit index. Index 0 takes commands and returns status. Index 1 is the track register, index 2 the sector register and index 3 the data register. The block does not model a drive mechanism. Instead it keeps a physical track number and moves one whole track at a time between the host and an external track buffer RAM. The host moves that data byte by byte through the data register, and a request flag paces each step.

A second, side-effect-free read port returns a flag byte. It holds the interrupt and data-request flags, a flag that is set when the head is off track 0, and an index flag driven by a frame tick. The track length is a configuration input. A length of zero marks the controller as absent: every register and the flag port then read as all ones, and writes do nothing. The buffer address for a transfer is length × (2 × physical track + side). The buffer RAM is expected to return read data one cycle after its read strobe.

Top module: `flop_track_ctrl`

## Requirements
- R1: A write to index 0 clears the interrupt flag, and its bits 7:4 select the command. Codes other than 0x0, 0x1, 0x9, 0xB and 0xD (for example 0xF, 0x5) change nothing else.
- R2: Command 0x0 (home) sets the track register and the physical track to 0, sets status to 4 and raises the interrupt flag.
- R3: Command 0x1 (seek) copies the data register into the track register and the physical track, raises the interrupt flag, and sets status to 4 if that value is 0, otherwise to 0.
- R4: Command 0x9 (track read) and command 0xB (track write) take the side from command bit 3. They set status to 3, raise the request flag and load a remaining-byte count with the track length. The transfer starts at buffer address length × (2 × physical track + side).
- R5: During a track read, bufRdEn is high with the start address in the command cycle, and the first byte is in the data register two cycles later. Each data-register read while the request flag is high returns the current byte. If bytes remain, that read also strobes a fetch of the next address, and the next byte is readable two cycles after the read. The read that empties the count instead drops the request flag, sets status 0 and raises the interrupt flag.
- R6: During a track write, each data-register write while the request flag is high drives bufWrEn, the current address and the byte in that same cycle, then advances the address. The write that empties the count drops the request flag, sets status 0 and raises the interrupt flag.
- R7: Command 0xD (halt) zeroes the count, drops the request flag, sets status 0 and sets the interrupt flag to command bit 0. A data-register access after it causes no buffer strobe.
- R8: Reading index 0 returns the status and clears the interrupt flag. Reads of indices 1 to 3 return their register and have no side effect outside a transfer. Every read returns the byte in bits 7:0 with bits 15:8 zero.
- R9: The flag port reads 0x0090, OR 0x02 while the interrupt flag is set, OR 0x01 while the request flag is set, OR 0x40 while the physical track is nonzero, OR 0x20 while the index counter is nonzero.
- R10: The index counter advances on each frameTick cycle through 0 to 19 and then returns to 0, so the 0x20 flag is low for one frame in twenty.
- R11: While trackLen is 0, rdData and auxData read 0xFFFF, register writes change no state, and bufRdEn and bufWrEn stay low.
- R12: Register writes use only bits 7:0 of wrData. A write to index 1 changes the track register but not the physical track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trackLen | input | LEN_W | Bytes per track; 0 disables the controller |
| frameTick | input | 1 | One-cycle pulse per video frame, advances the index counter |
| regSel | input | 2 | Register index: 0 command/status, 1 track, 2 sector, 3 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects taken at the clock edge) |
| wrData | input | 16 | Write data; only bits 7:0 are used |
| rdData | output | 16 | Read data of the selected register |
| auxData | output | 16 | Flag byte port |
| bufAddr | output | LEN_W+9 | Track buffer byte address |
| bufRdEn | output | 1 | Track buffer read strobe |
| bufWrEn | output | 1 | Track buffer write strobe |
| bufWrData | output | 8 | Byte written to the track buffer |
| bufRdData | input | 8 | Byte from the track buffer, valid one cycle after bufRdEn |

## Verification
rdData and the buffer strobes and address are combinational in the cycle of the access, so the bench samples them one time step after driving the inputs, before the clock edge. Flag and register changes caused by an access are due at the edge that ends it and are checked from the next cycle on. A fetched byte passes the RAM register and then the data register, so it is due two cycles after its strobe. The reference model tracks that two-stage delay, and the bench leaves a gap cycle before each data read. The flag port is compared with the model in every cycle.

// File: rtl/flop_pkg.sv
package flop_pkg;

  localparam int BYTE_W = 8;

  // command codes, upper nibble of a command write
  localparam logic [3:0] OP_HOME  = 4'h0;
  localparam logic [3:0] OP_SEEK  = 4'h1;
  localparam logic [3:0] OP_RDTRK = 4'h9;
  localparam logic [3:0] OP_WRTRK = 4'hB;
  localparam logic [3:0] OP_HALT  = 4'hD;

  // status register values
  localparam logic [BYTE_W-1:0] ST_IDLE = 8'd0;
  localparam logic [BYTE_W-1:0] ST_XFER = 8'd3;
  localparam logic [BYTE_W-1:0] ST_TRK0 = 8'd4;

  // strobes from the control to the datapath
  typedef struct packed {
    logic homeTrk;
    logic seekTrk;
    logic trkWr;
    logic secWr;
    logic dataWr;
    logic xferStart;
    logic fetchReq;
    logic fetchNext;
    logic fetchLoad;
    logic storeByte;
    logic addrStep;
  } dpStrobe_t;

endpackage

// File: rtl/flop_ctrl.sv
module flop_ctrl
  import flop_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  trackLen,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [3:0]        cmdOp,
  input  logic              irqBit,
  input  logic              dataIsZero,
  output dpStrobe_t         stb,
  output logic [BYTE_W-1:0] statusReg,
  output logic              irqFlag,
  output logic              drqFlag
);

  logic             enable;
  logic             wrAcc;
  logic             rdAcc;
  logic             cmdWr;
  logic             statusRd;
  logic             dataRdStep;
  logic             dataWrStep;
  logic             spanDone;
  logic             loadPend;
  logic [LEN_W-1:0] spanCnt;
  logic [LEN_W-1:0] spanNext;

  always_comb begin
    enable     = |trackLen;
    wrAcc      = regWr && enable;
    rdAcc      = regRd && !regWr && enable;
    cmdWr      = wrAcc && (regSel == 2'd0);
    statusRd   = rdAcc && (regSel == 2'd0);
    dataRdStep = rdAcc && (regSel == 2'd3) && drqFlag;
    dataWrStep = wrAcc && (regSel == 2'd3) && drqFlag;
    spanNext   = spanCnt - LEN_W'(1);
    spanDone   = (spanNext == '0);
  end

  always_comb begin
    stb           = '0;
    stb.homeTrk   = cmdWr && (cmdOp == OP_HOME);
    stb.seekTrk   = cmdWr && (cmdOp == OP_SEEK);
    stb.trkWr     = wrAcc && (regSel == 2'd1);
    stb.secWr     = wrAcc && (regSel == 2'd2);
    stb.dataWr    = wrAcc && (regSel == 2'd3);
    stb.xferStart = cmdWr && ((cmdOp == OP_RDTRK) || (cmdOp == OP_WRTRK));
    stb.fetchNext = dataRdStep && !spanDone;
    stb.fetchReq  = (cmdWr && (cmdOp == OP_RDTRK)) || stb.fetchNext;
    stb.fetchLoad = loadPend;
    stb.storeByte = dataWrStep;
    stb.addrStep  = stb.fetchNext || dataWrStep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadPend  <= 1'b0;
      spanCnt   <= '0;
      statusReg <= ST_IDLE;
      irqFlag   <= 1'b0;
      drqFlag   <= 1'b0;
    end else begin
      loadPend <= stb.fetchReq;
      if (cmdWr) begin
        irqFlag <= 1'b0;
        case (cmdOp)
          OP_HOME: begin
            statusReg <= ST_TRK0;
            irqFlag   <= 1'b1;
          end
          OP_SEEK: begin
            statusReg <= dataIsZero ? ST_TRK0 : ST_IDLE;
            irqFlag   <= 1'b1;
          end
          OP_RDTRK, OP_WRTRK: begin
            statusReg <= ST_XFER;
            drqFlag   <= 1'b1;
            spanCnt   <= trackLen;
          end
          OP_HALT: begin
            spanCnt   <= '0;
            drqFlag   <= 1'b0;
            statusReg <= ST_IDLE;
            irqFlag   <= irqBit;
          end
          default: ;
        endcase
      end else if (dataRdStep || dataWrStep) begin
        spanCnt <= spanNext;
        if (spanDone) begin
          drqFlag   <= 1'b0;
          statusReg <= ST_IDLE;
          irqFlag   <= 1'b1;
        end
      end else if (statusRd) begin
        irqFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/flop_dp.sv
module flop_dp
  import flop_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int IDX_WRAP = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  dpStrobe_t                  stb,
  input  logic [LEN_W-1:0]           trackLen,
  input  logic [BYTE_W-1:0]          wrByte,
  input  logic                       frameTick,
  input  logic [BYTE_W-1:0]          bufRdData,
  output logic [BYTE_W-1:0]          trackReg,
  output logic [BYTE_W-1:0]          sectorReg,
  output logic [BYTE_W-1:0]          dataReg,
  output logic                       dataIsZero,
  output logic                       physNonZero,
  output logic                       indexNonZero,
  output logic [LEN_W+BYTE_W:0]      bufAddr,
  output logic [BYTE_W-1:0]          bufWrData
);

  localparam int ADDR_W = LEN_W + BYTE_W + 1;
  localparam int IDX_W  = (IDX_WRAP > 1) ? $clog2(IDX_WRAP) : 1;

  logic [BYTE_W-1:0] physTrk;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] baseAddr;
  logic [BYTE_W:0]   slotIdx;
  logic [IDX_W-1:0]  idxCnt;

  // slot = 2*track + side, side from command bit 3
  always_comb begin
    slotIdx  = {physTrk, wrByte[3]};
    baseAddr = ADDR_W'(trackLen) * ADDR_W'(slotIdx);
    if (stb.xferStart)
      bufAddr = baseAddr;
    else if (stb.fetchNext)
      bufAddr = addrReg + ADDR_W'(1);
    else
      bufAddr = addrReg;
    bufWrData    = wrByte;
    dataIsZero   = (dataReg == '0);
    physNonZero  = |physTrk;
    indexNonZero = |idxCnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trackReg  <= '0;
      physTrk   <= '0;
      sectorReg <= '0;
      dataReg   <= '0;
      addrReg   <= '0;
    end else begin
      if (stb.homeTrk) begin
        trackReg <= '0;
        physTrk  <= '0;
      end else if (stb.seekTrk) begin
        trackReg <= dataReg;
        physTrk  <= dataReg;
      end else if (stb.trkWr) begin
        trackReg <= wrByte;
      end
      if (stb.secWr)
        sectorReg <= wrByte;
      if (stb.dataWr)
        dataReg <= wrByte;
      else if (stb.fetchLoad)
        dataReg <= bufRdData;
      if (stb.xferStart)
        addrReg <= baseAddr;
      else if (stb.addrStep)
        addrReg <= addrReg + ADDR_W'(1);
    end
  end

  generate
    if (IDX_WRAP > 1) begin : gIdxCount
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          idxCnt <= '0;
        else if (frameTick)
          idxCnt <= (idxCnt == IDX_W'(IDX_WRAP - 1)) ? '0 : idxCnt + IDX_W'(1);
      end
    end else begin : gIdxFlat
      logic unusedTick;
      assign unusedTick = frameTick;
      assign idxCnt     = '0;
    end
  endgenerate

endmodule

// File: rtl/flop_track_ctrl.sv
module flop_track_ctrl
  import flop_pkg::*;
#(
  parameter  int LEN_W    = 16,
  parameter  int IDX_WRAP = 20,
  localparam int ADDR_W   = LEN_W + BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  trackLen,
  input  logic              frameTick,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic [15:0]       auxData,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              bufRdEn,
  output logic              bufWrEn,
  output logic [7:0]        bufWrData,
  input  logic [7:0]        bufRdData
);

  dpStrobe_t         stb;
  logic [BYTE_W-1:0] statusReg;
  logic [BYTE_W-1:0] trackReg;
  logic [BYTE_W-1:0] sectorReg;
  logic [BYTE_W-1:0] dataReg;
  logic              irqFlag;
  logic              drqFlag;
  logic              dataIsZero;
  logic              physNonZero;
  logic              indexNonZero;
  logic              enable;
  logic [7:0]        unusedHi;

  assign unusedHi = wrData[15:8];
  assign enable   = |trackLen;

  flop_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trackLen   (trackLen),
    .regSel     (regSel),
    .regWr      (regWr),
    .regRd      (regRd),
    .cmdOp      (wrData[7:4]),
    .irqBit     (wrData[0]),
    .dataIsZero (dataIsZero),
    .stb        (stb),
    .statusReg  (statusReg),
    .irqFlag    (irqFlag),
    .drqFlag    (drqFlag)
  );

  flop_dp #(.LEN_W(LEN_W), .IDX_WRAP(IDX_WRAP)) uDp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .trackLen     (trackLen),
    .wrByte       (wrData[7:0]),
    .frameTick    (frameTick),
    .bufRdData    (bufRdData),
    .trackReg     (trackReg),
    .sectorReg    (sectorReg),
    .dataReg      (dataReg),
    .dataIsZero   (dataIsZero),
    .physNonZero  (physNonZero),
    .indexNonZero (indexNonZero),
    .bufAddr      (bufAddr),
    .bufWrData    (bufWrData)
  );

  assign bufRdEn = stb.fetchReq;
  assign bufWrEn = stb.storeByte;

  always_comb begin
    if (!enable) begin
      rdData = 16'hFFFF;
    end else begin
      case (regSel)
        2'd0:    rdData = {8'h00, statusReg};
        2'd1:    rdData = {8'h00, trackReg};
        2'd2:    rdData = {8'h00, sectorReg};
        default: rdData = {8'h00, dataReg};
      endcase
    end
    if (!enable)
      auxData = 16'hFFFF;
    else
      auxData = {8'h00, 1'b1, physNonZero, indexNonZero, 1'b1, 2'b00, irqFlag, drqFlag};
  end

endmodule

// File: rtl/flop_track_chk.sv
module flop_track_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] trackLen,
  input logic [1:0]       regSel,
  input logic             regWr,
  input logic             regRd,
  input logic [15:0]      wrData,
  input logic [15:0]      rdData,
  input logic [15:0]      auxData,
  input logic             bufRdEn,
  input logic             bufWrEn
);

  logic on;
  logic cmdW;
  assign on   = |trackLen;
  assign cmdW = on && regWr && (regSel == 2'd0);

  AST_UNKNOWN_CMD_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdW && wrData[7:4] == 4'hF) |=> (trackLen == '0 || !auxData[1])); // R1

  AST_HOME_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdW && wrData[7:4] == 4'h0) |=> (trackLen == '0 || (!auxData[6] && auxData[1]))); // R2

  AST_SEEK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdW && wrData[7:4] == 4'h1) |=> (trackLen == '0 || auxData[1])); // R3

  AST_XFER_RAISES_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdW && (wrData[7:4] == 4'h9 || wrData[7:4] == 4'hB)) |=> (trackLen == '0 || auxData[0])); // R4

  AST_STORE_NEEDS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrEn |-> auxData[0]); // R6

  AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdW && wrData[7:4] == 4'hD) |=> (trackLen == '0 || (!auxData[0] && auxData[1] == $past(wrData[0])))); // R7

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (on && regRd && !regWr && regSel == 2'd0) |=> (trackLen == '0 || !auxData[1])); // R8

  AST_FLAG_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    on |-> (auxData[15:8] == 8'h00 && auxData[7] && auxData[4] && auxData[3:2] == 2'b00)); // R9

  AST_OFF_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && regRd) |-> (rdData == 16'hFFFF && auxData == 16'hFFFF)); // R11

  AST_OFF_NO_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> (!bufWrEn && !bufRdEn)); // R11

endmodule

bind flop_track_ctrl flop_track_chk #(.LEN_W(LEN_W)) uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trackLen (trackLen),
  .regSel   (regSel),
  .regWr    (regWr),
  .regRd    (regRd),
  .wrData   (wrData),
  .rdData   (rdData),
  .auxData  (auxData),
  .bufRdEn  (bufRdEn),
  .bufWrEn  (bufWrEn)
);

// File: tb/tb_flop_track_ctrl.sv
module tb_flop_track_ctrl;

  localparam int LEN_W  = 16;
  localparam int ADDR_W = LEN_W + 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [LEN_W-1:0]  trackLen;
  logic              frameTick;
  logic [1:0]        regSel;
  logic              regWr;
  logic              regRd;
  logic [15:0]       wrData;
  logic [15:0]       rdData;
  logic [15:0]       auxData;
  logic [ADDR_W-1:0] bufAddr;
  logic              bufRdEn;
  logic              bufWrEn;
  logic [7:0]        bufWrData;
  logic [7:0]        bufRdData;

  always #4 clk = ~clk;

  flop_track_ctrl dut (
    .clk(clk), .rst_n(rst_n), .trackLen(trackLen), .frameTick(frameTick),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .wrData(wrData),
    .rdData(rdData), .auxData(auxData), .bufAddr(bufAddr), .bufRdEn(bufRdEn),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData), .bufRdData(bufRdData)
  );

  // external track buffer, one cycle read latency
  logic [7:0] ram [256];
  bit         ramSet [256];
  logic [7:0] ramQ;

  function automatic int seedByte(int a);
    return (a * 37 + 11) & 255;
  endfunction

  always @(posedge clk) begin
    if (bufWrEn) begin
      ram[bufAddr[7:0]]    <= bufWrData;
      ramSet[bufAddr[7:0]] <= 1'b1;
    end
    if (bufRdEn)
      ramQ <= ramSet[bufAddr[7:0]] ? ram[bufAddr[7:0]] : 8'(seedByte(int'(bufAddr[7:0])));
  end
  assign bufRdData = ramQ;

  // reference model state
  int len;
  int mTrack, mPhys, mSector, mData, mStat, mIrq, mDrq, mSpan, mAddr, mIdx;
  int mPend, mPendVal;
  int shadow [256];

  int    nCmp = 0;
  int    nBad = 0;
  string curReq = "R9";
  bit    finished = 1'b0;

  assign trackLen = LEN_W'(len);

  task automatic chk(string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  task automatic cyc(int sel, bit wr, bit rd, int d, bit tick);
    int en, wrA, rdA, op, expRdEn, expWrEn, expAddr, expAux, expRd, expByte;
    regSel = 2'(sel); regWr = wr; regRd = rd; wrData = 16'(d); frameTick = tick;
    #1;
    en  = (len != 0);
    wrA = wr && en;
    rdA = rd && !wr && en;
    op  = (d >> 4) & 15;
    expAux = en ? ('h90 | (mIrq << 1) | mDrq | ((mPhys != 0) << 6) | ((mIdx != 0) << 5)) : 'hFFFF;
    chk("auxData", int'(auxData), expAux);
    if (rd) begin
      if (!en) expRd = 'hFFFF;
      else case (sel)
        0: expRd = mStat;
        1: expRd = mTrack;
        2: expRd = mSector;
        default: expRd = mData;
      endcase
      chk("rdData", int'(rdData), expRd);
    end
    expRdEn = 0; expWrEn = 0; expAddr = 0; expByte = d & 255;
    if (wrA && sel == 0 && op == 9) begin
      expRdEn = 1; expAddr = len * (2 * mPhys + ((d >> 3) & 1));
    end
    if (rdA && sel == 3 && mDrq && mSpan != 1) begin
      expRdEn = 1; expAddr = mAddr + 1;
    end
    if (wrA && sel == 3 && mDrq) begin
      expWrEn = 1; expAddr = mAddr;
    end
    chk("bufRdEn", int'(bufRdEn), expRdEn);
    chk("bufWrEn", int'(bufWrEn), expWrEn);
    if (expRdEn || expWrEn) chk("bufAddr", int'(bufAddr), expAddr);
    if (expWrEn) chk("bufWrData", int'(bufWrData), expByte);
    @(posedge clk);
    if (mPend) begin mData = mPendVal; mPend = 0; end
    if (wrA) begin
      case (sel)
        0: begin
          mIrq = 0;
          case (op)
            0: begin mTrack = 0; mPhys = 0; mStat = 4; mIrq = 1; end
            1: begin mTrack = mData; mPhys = mData; mStat = (mData == 0) ? 4 : 0; mIrq = 1; end
            9, 11: begin
              mAddr = len * (2 * mPhys + ((d >> 3) & 1));
              mSpan = len; mStat = 3; mDrq = 1;
              if (op == 9) begin mPend = 1; mPendVal = shadow[mAddr & 255]; end
            end
            13: begin mSpan = 0; mDrq = 0; mStat = 0; mIrq = d & 1; end
            default: ;
          endcase
        end
        1: mTrack = d & 255;
        2: mSector = d & 255;
        default: begin
          if (mDrq) begin
            shadow[mAddr & 255] = d & 255;
            mAddr++; mSpan--;
            if (mSpan == 0) begin mDrq = 0; mStat = 0; mIrq = 1; end
          end
          mData = d & 255;
        end
      endcase
    end else if (rdA) begin
      if (sel == 0) mIrq = 0;
      else if (sel == 3 && mDrq) begin
        mSpan--;
        if (mSpan != 0) begin
          mAddr++; mPend = 1; mPendVal = shadow[mAddr & 255];
        end else begin
          mDrq = 0; mStat = 0; mIrq = 1;
        end
      end
    end
    if (tick) mIdx = (mIdx + 1) % 20;
    @(negedge clk);
  endtask

  task automatic idle();            cyc(0, 0, 0, 0, 0); endtask
  task automatic wreg(int s, int d); cyc(s, 1, 0, d, 0); endtask
  task automatic rreg(int s);        cyc(s, 0, 1, 0, 0); endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      shadow[i] = seedByte(i);
      ramSet[i] = 1'b0;
    end
    mTrack = 0; mPhys = 0; mSector = 0; mData = 0; mStat = 0; mIrq = 0;
    mDrq = 0; mSpan = 0; mAddr = 0; mIdx = 0; mPend = 0; mPendVal = 0;
    len = 6;
    rst_n = 1'b0; regSel = 0; regWr = 0; regRd = 0; wrData = 0; frameTick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state and flag encoding
    curReq = "R9";  idle(); rreg(0);
    // register map, low byte only
    curReq = "R12"; wreg(1, 'h1A5); rreg(1); wreg(2, 'h233); rreg(2); wreg(3, 'h05); rreg(3); idle();
    // seek to a nonzero track, status read clears irq
    curReq = "R3";  wreg(0, 'h10); idle();
    curReq = "R8";  rreg(0); rreg(0); rreg(1);
    curReq = "R3";  wreg(3, 0); wreg(0, 'h10); rreg(0);
    // home
    curReq = "R2";  wreg(3, 2); wreg(0, 'h10); idle(); wreg(0, 'h00); rreg(1); rreg(0); idle();
    // track read, side 1 on track 2
    curReq = "R4";  wreg(3, 2); wreg(0, 'h10); wreg(0, 'h98); idle();
    curReq = "R5";  for (int i = 0; i < 6; i++) begin rreg(3); idle(); end
    rreg(0);
    // track write, side 0, then read it back
    curReq = "R6";  wreg(0, 'hB0);
    for (int i = 0; i < 6; i++) wreg(3, 'hC0 + i);
    rreg(0);
    curReq = "R5";  wreg(0, 'h90); idle();
    for (int i = 0; i < 6; i++) begin rreg(3); idle(); end
    // other length, track 1 side 0
    curReq = "R4";  len = 3; wreg(3, 1); wreg(0, 'h10); wreg(0, 'h90); idle();
    curReq = "R5";  for (int i = 0; i < 3; i++) begin rreg(3); idle(); end
    len = 6;
    // halt mid-transfer
    curReq = "R7";  wreg(0, 'h98); idle(); rreg(3); idle(); wreg(0, 'hD1); rreg(3); idle();
    wreg(0, 'hB0); wreg(3, 'h44); wreg(0, 'hD0); wreg(3, 'h55); rreg(0);
    // unknown and mode commands
    curReq = "R1";  wreg(0, 'hD1); wreg(0, 'hFE); rreg(1); rreg(0); wreg(0, 'hD1); wreg(0, 'h50); rreg(3); idle();
    // index counter
    curReq = "R10"; for (int i = 0; i < 45; i++) cyc(0, 0, 0, 0, 1);
    idle();
    // disabled controller
    curReq = "R11"; len = 0;
    rreg(0); rreg(1); rreg(2); rreg(3);
    wreg(1, 'h77); wreg(0, 'h00); wreg(0, 'hB0); wreg(3, 'h11); cyc(0, 0, 0, 0, 1);
    len = 6;
    rreg(1); rreg(2); rreg(3); rreg(0); idle();

    finished = 1'b1;
    summary();
  end

endmodule